// File: doc/BRIEF.md
# Line Statistics Accumulator

This block watches the stream of valid pixels from one sensor output during calibration and produces the figures used to qualify that output. For each line it reports the pixel count, the sum of levels, the exact integer mean, the largest distance of any pixel from that mean, and a signed imbalance sum that compares each odd-position pixel with the even-position pixel that follows it. Scaling the imbalance to a percentage is left to software.

It also follows one chosen pixel position across many lines. Once a parameterised number of samples has been taken, it reports their sum, their sum of squares, and the variance numerator, which is the sum of squares minus the squared sum divided by the sample count. The variance divided by the sample count, and its square root, are left to the consumer.

Statistics are gathered as the pixels arrive. The deviation figure needs the mean, so it is formed from the running minimum and maximum once the line has closed. One shared sequential divider produces the exact mean and the squared-sum quotient. Results appear as single-cycle strobes on registered outputs, and those outputs hold their values until the next report.

Top module: `linestat_core`

## Requirements
- R1: After reset, `stat_valid`, `noise_valid` and `busy` are low, and every result output is zero.
- R2: `stat_count` and `stat_sum` cover exactly the pixels with `in_valid` high from the `line_start` cycle through the `line_end` cycle, both cycles included. Pixels seen before `line_start` are discarded.
- R3: `stat_mean` equals floor(`stat_sum` / `stat_count`), computed exactly.
- R4: `stat_maxdev` equals the larger of (line maximum − mean) and (mean − line minimum).
- R5: `stat_imb` is the signed sum of (odd pixel − next even pixel), where `in_odd`=1 marks an odd pixel. An even pixel with no pending odd pixel is skipped. A second odd pixel replaces the pending one.
- R6: A line with no valid pixels reports a count, sum, mean, deviation and imbalance of zero.
- R7: `stat_valid` is a one-cycle pulse after `line_end`. `busy` is high from the cycle after `line_end` until the report, and the results hold between reports.
- R8: The pixel at 0-based valid index `noise_idx` in each line is one sample. When `NOISE_LINES` samples have been taken, `noise_valid` pulses once, after that line's `stat_valid`, with the sum, the sum of squares, and sum of squares − floor(sum² / `NOISE_LINES`).
- R9: A line that has no pixel at index `noise_idx` adds no sample, and pixels outside a line are never sampled.
- R10: Cycles with `in_valid` low have no effect on any statistic, whatever `in_data` and `in_odd` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel qualifier |
| in_data | input | DATA_W | Pixel level |
| in_odd | input | 1 | 1 = odd-position pixel, 0 = even |
| line_start | input | 1 | First cycle of a line; clears the line accumulators |
| line_end | input | 1 | Last cycle of a line; starts the report |
| noise_idx | input | CNT_W | Valid-pixel index sampled for noise |
| busy | output | 1 | Report in progress |
| stat_valid | output | 1 | Line result strobe |
| stat_count | output | CNT_W | Valid pixels in the line |
| stat_sum | output | SUM_W | Sum of pixel levels |
| stat_mean | output | DATA_W | Exact integer mean |
| stat_maxdev | output | DATA_W | Largest distance from the mean |
| stat_imb | output | IMB_W | Signed odd-minus-even sum |
| noise_valid | output | 1 | Noise batch strobe |
| noise_sum | output | NS_W | Sum of samples |
| noise_sumsq | output | SQ_W | Sum of squared samples |
| noise_varnum | output | SQ_W | Variance numerator |

## Verification
A corrupted running minimum, maximum or pending-odd register shows up only in the line's `stat_maxdev` or `stat_imb`, at the report that follows `line_end` roughly fifty cycles later. The bench therefore arranges lines whose deviation comes from the high side, from the low side and from zero, and imbalance patterns that mix and misorder odd and even pixels. A wrong divider step or sample counter shows up in `stat_mean` or the noise figures. The noise errors surface only when a batch closes, so two complete batches are run, and they include lines that must contribute no sample.

// File: rtl/linestat_pkg.sv
// Package: shared control states for the line statistics accumulator.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package linestat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEAN_GO,
        ST_MEAN_WAIT,
        ST_REPORT,
        ST_NOISE_GO,
        ST_NOISE_WAIT
    } ls_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/linestat_line_acc.sv
// Per-line running statistics: count, sum, minimum, maximum and the signed
// odd-minus-following-even sum. Exposes next-state values so the parent can
// snapshot a line closed by a pixel in the same cycle as line_end.
// Assumes at most 2**CNT_W-1 valid pixels per line.
module linestat_line_acc #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 13,
    parameter int SUM_W  = 29,
    parameter int IMB_W  = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    input  logic                     in_odd,
    input  logic                     line_start,
    input  logic                     line_end,
    output logic [CNT_W-1:0]         nx_cnt,
    output logic [SUM_W-1:0]         nx_sum,
    output logic [DATA_W-1:0]        nx_min,
    output logic [DATA_W-1:0]        nx_max,
    output logic signed [IMB_W-1:0]  nx_imb
);

    logic [CNT_W-1:0]        cnt_q;
    logic [SUM_W-1:0]        sum_q;
    logic [DATA_W-1:0]       min_q, max_q, hold_q;
    logic signed [IMB_W-1:0] imb_q;
    logic                    have_q;

    logic [CNT_W-1:0]        b_cnt;
    logic [SUM_W-1:0]        b_sum;
    logic [DATA_W-1:0]       b_min, b_max;
    logic signed [IMB_W-1:0] b_imb;
    logic                    b_have;
    logic [DATA_W-1:0]       nx_hold;
    logic                    nx_have;
    logic signed [DATA_W:0]  diff;

    // Base values: line_start discards anything gathered before it.
    always_comb begin
        b_cnt  = line_start ? '0 : cnt_q;
        b_sum  = line_start ? '0 : sum_q;
        b_min  = line_start ? '0 : min_q;
        b_max  = line_start ? '0 : max_q;
        b_imb  = line_start ? '0 : imb_q;
        b_have = line_start ? 1'b0 : have_q;
    end

    // Next-state update for one qualified pixel.
    always_comb begin
        nx_cnt  = b_cnt;
        nx_sum  = b_sum;
        nx_min  = b_min;
        nx_max  = b_max;
        nx_imb  = b_imb;
        nx_hold = hold_q;
        nx_have = b_have;
        diff    = $signed({1'b0, hold_q}) - $signed({1'b0, in_data});
        if (in_valid) begin
            nx_cnt = b_cnt + 1'b1;
            nx_sum = b_sum + SUM_W'(in_data);
            if (b_cnt == '0) begin
                nx_min = in_data;
                nx_max = in_data;
            end else begin
                if (in_data < b_min) nx_min = in_data;
                if (in_data > b_max) nx_max = in_data;
            end
            if (in_odd) begin
                nx_hold = in_data;
                nx_have = 1'b1;
            end else if (b_have) begin
                nx_imb  = b_imb + {{(IMB_W-DATA_W-1){diff[DATA_W]}}, diff};
                nx_have = 1'b0;
            end
        end
    end

    // State registers; line_end hands the line over and clears.
    always_ff @(posedge clk) begin
        if (!rst_n || line_end) begin
            cnt_q  <= '0;
            sum_q  <= '0;
            min_q  <= '0;
            max_q  <= '0;
            imb_q  <= '0;
            hold_q <= '0;
            have_q <= 1'b0;
        end else begin
            cnt_q  <= nx_cnt;
            sum_q  <= nx_sum;
            min_q  <= nx_min;
            max_q  <= nx_max;
            imb_q  <= nx_imb;
            hold_q <= nx_hold;
            have_q <= nx_have;
        end
    end

endmodule

// File: rtl/linestat_noise_acc.sv
// Cross-line accumulator: takes the pixel at a chosen valid index of every
// line, sums it and its square, and after NOISE_LINES samples raises a
// pending flag with a snapshot until the parent takes it.
// Assumes the parent takes a pending batch before the next batch closes.
module linestat_noise_acc #(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 13,
    parameter int NOISE_LINES = 100,
    parameter int NL_W        = 7,
    parameter int NS_W        = 23,
    parameter int SQ_W        = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              line_start,
    input  logic              line_end,
    input  logic [CNT_W-1:0]  sel_idx,
    input  logic              take,
    output logic              pend,
    output logic [NS_W-1:0]   snap_sum,
    output logic [SQ_W-1:0]   snap_sq
);

    logic [CNT_W-1:0] idx_q, b_idx;
    logic             in_line_q;
    logic [NL_W-1:0]  n_q;
    logic [NS_W-1:0]  s_q, s_nx;
    logic [SQ_W-1:0]  q_q, q_nx;
    logic             hit, closes;

    // Sample selection and running sums for a hit.
    always_comb begin
        b_idx  = line_start ? '0 : idx_q;
        hit    = in_valid && (line_start || in_line_q) && (b_idx == sel_idx);
        s_nx   = s_q + NS_W'(in_data);
        q_nx   = q_q + SQ_W'(in_data) * SQ_W'(in_data);
        closes = hit && (n_q == NL_W'(NOISE_LINES - 1));
    end

    // Index counter and inside-line flag.
    always_ff @(posedge clk) begin
        if (!rst_n || line_end) begin
            idx_q     <= '0;
            in_line_q <= 1'b0;
        end else begin
            idx_q     <= in_valid ? b_idx + 1'b1 : b_idx;
            in_line_q <= in_line_q | line_start;
        end
    end

    // Batch sums, snapshot and pending handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q      <= '0;
            s_q      <= '0;
            q_q      <= '0;
            pend     <= 1'b0;
            snap_sum <= '0;
            snap_sq  <= '0;
        end else begin
            if (closes) begin
                n_q      <= '0;
                s_q      <= '0;
                q_q      <= '0;
                snap_sum <= s_nx;
                snap_sq  <= q_nx;
                pend     <= 1'b1;
            end else begin
                if (hit) begin
                    n_q <= n_q + 1'b1;
                    s_q <= s_nx;
                    q_q <= q_nx;
                end
                if (take) pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/linestat_divider.sv
// Unsigned restoring divider, one quotient bit per cycle, DVD_W cycles
// from start to the done pulse. Assumes a non-zero divisor and no start
// while a division runs.
module linestat_divider #(
    parameter int DVD_W = 46,
    parameter int DVS_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [DVD_W-1:0] quotient
);

    localparam int STEP_W = $clog2(DVD_W + 1);

    logic [DVS_W-1:0]  rem_q, dvs_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic [DVS_W:0]    rem_sh, rem_sub;
    logic              ge;

    // One restoring step: shift in the next dividend bit, try a subtract.
    always_comb begin
        rem_sh  = {rem_q, quotient[DVD_W-1]};
        ge      = rem_sh >= {1'b0, dvs_q};
        rem_sub = rem_sh - {1'b0, dvs_q};
    end

    // Iteration control and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            dvs_q    <= '0;
            step_q   <= '0;
            run_q    <= 1'b0;
            done     <= 1'b0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quotient <= dividend;
                dvs_q    <= divisor;
                rem_q    <= '0;
                step_q   <= STEP_W'(DVD_W);
                run_q    <= 1'b1;
            end else if (run_q) begin
                rem_q    <= ge ? rem_sub[DVS_W-1:0] : rem_sh[DVS_W-1:0];
                quotient <= {quotient[DVD_W-2:0], ge};
                step_q   <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/linestat_core.sv
// Top of the line statistics accumulator. Snapshots the line statistics at
// line_end, divides for the exact mean, forms the deviation from the
// minimum and maximum, and, when a noise batch is pending, divides the
// squared sample sum to give the variance numerator.
// Assumes line_end is not raised while busy is high; such a line is not
// reported.
module linestat_core #(
    parameter int DATA_W      = 16,
    parameter int MAX_PIX     = 7500,
    parameter int NOISE_LINES = 100,
    localparam int CNT_W = $clog2(MAX_PIX + 1),
    localparam int SUM_W = DATA_W + CNT_W,
    localparam int IMB_W = DATA_W + CNT_W + 1,
    localparam int NL_W  = $clog2(NOISE_LINES + 1),
    localparam int NS_W  = DATA_W + NL_W,
    localparam int SQ_W  = 2 * DATA_W + NL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    input  logic                     in_odd,
    input  logic                     line_start,
    input  logic                     line_end,
    input  logic [CNT_W-1:0]         noise_idx,
    output logic                     busy,
    output logic                     stat_valid,
    output logic [CNT_W-1:0]         stat_count,
    output logic [SUM_W-1:0]         stat_sum,
    output logic [DATA_W-1:0]        stat_mean,
    output logic [DATA_W-1:0]        stat_maxdev,
    output logic signed [IMB_W-1:0] stat_imb,
    output logic                     noise_valid,
    output logic [NS_W-1:0]          noise_sum,
    output logic [SQ_W-1:0]          noise_sumsq,
    output logic [SQ_W-1:0]          noise_varnum
);
    import linestat_pkg::*;

    localparam int DVD_W = imax(2 * NS_W, SUM_W);
    localparam int DVS_W = imax(CNT_W, NL_W);

    ls_state_t               state_q;
    logic [CNT_W-1:0]        nx_cnt, snap_cnt;
    logic [SUM_W-1:0]        nx_sum, snap_sum;
    logic [DATA_W-1:0]       nx_min, nx_max, snap_min, snap_max, mean_q;
    logic signed [IMB_W-1:0] nx_imb, snap_imb;
    logic                    nz_pend, nz_take;
    logic [NS_W-1:0]         nz_snap_sum, nz_sum_q;
    logic [SQ_W-1:0]         nz_snap_sq, nz_sq_q;
    logic                    div_start, div_done;
    logic [DVD_W-1:0]        div_dvd, div_quo, nz_ext;
    logic [DVS_W-1:0]        div_dvs;
    logic [DATA_W-1:0]       dev_up, dev_dn;

    linestat_line_acc #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .IMB_W(IMB_W)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_odd(in_odd), .line_start(line_start), .line_end(line_end),
        .nx_cnt(nx_cnt), .nx_sum(nx_sum), .nx_min(nx_min), .nx_max(nx_max),
        .nx_imb(nx_imb)
    );

    linestat_noise_acc #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .NOISE_LINES(NOISE_LINES),
        .NL_W(NL_W), .NS_W(NS_W), .SQ_W(SQ_W)
    ) u_noise (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .line_start(line_start), .line_end(line_end), .sel_idx(noise_idx),
        .take(nz_take), .pend(nz_pend), .snap_sum(nz_snap_sum),
        .snap_sq(nz_snap_sq)
    );

    linestat_divider #(
        .DVD_W(DVD_W), .DVS_W(DVS_W)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_dvd),
        .divisor(div_dvs), .done(div_done), .quotient(div_quo)
    );

    // Divider operand selection by phase.
    always_comb begin
        nz_ext    = DVD_W'(nz_sum_q);
        div_start = 1'b0;
        div_dvd   = DVD_W'(snap_sum);
        div_dvs   = DVS_W'(snap_cnt);
        nz_take   = (state_q == ST_REPORT) && nz_pend;
        if (state_q == ST_MEAN_GO) begin
            div_start = (snap_cnt != '0);
        end else if (state_q == ST_NOISE_GO) begin
            div_start = 1'b1;
            div_dvd   = nz_ext * nz_ext;
            div_dvs   = DVS_W'(NOISE_LINES);
        end
    end

    // Deviation candidates on each side of the mean.
    always_comb begin
        dev_up = snap_max - mean_q;
        dev_dn = mean_q - snap_min;
    end

    assign busy = (state_q != ST_IDLE);

    // Report sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            snap_cnt     <= '0;
            snap_sum     <= '0;
            snap_min     <= '0;
            snap_max     <= '0;
            snap_imb     <= '0;
            mean_q       <= '0;
            nz_sum_q     <= '0;
            nz_sq_q      <= '0;
            stat_valid   <= 1'b0;
            stat_count   <= '0;
            stat_sum     <= '0;
            stat_mean    <= '0;
            stat_maxdev  <= '0;
            stat_imb     <= '0;
            noise_valid  <= 1'b0;
            noise_sum    <= '0;
            noise_sumsq  <= '0;
            noise_varnum <= '0;
        end else begin
            stat_valid  <= 1'b0;
            noise_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (line_end) begin
                        snap_cnt <= nx_cnt;
                        snap_sum <= nx_sum;
                        snap_min <= nx_min;
                        snap_max <= nx_max;
                        snap_imb <= nx_imb;
                        state_q  <= ST_MEAN_GO;
                    end
                end
                ST_MEAN_GO: begin
                    if (snap_cnt == '0) begin
                        mean_q  <= '0;
                        state_q <= ST_REPORT;
                    end else begin
                        state_q <= ST_MEAN_WAIT;
                    end
                end
                ST_MEAN_WAIT: begin
                    if (div_done) begin
                        mean_q  <= div_quo[DATA_W-1:0];
                        state_q <= ST_REPORT;
                    end
                end
                ST_REPORT: begin
                    stat_valid  <= 1'b1;
                    stat_count  <= snap_cnt;
                    stat_sum    <= snap_sum;
                    stat_mean   <= mean_q;
                    stat_maxdev <= (dev_up > dev_dn) ? dev_up : dev_dn;
                    stat_imb    <= snap_imb;
                    if (nz_pend) begin
                        nz_sum_q <= nz_snap_sum;
                        nz_sq_q  <= nz_snap_sq;
                        state_q  <= ST_NOISE_GO;
                    end else begin
                        state_q  <= ST_IDLE;
                    end
                end
                ST_NOISE_GO: begin
                    state_q <= ST_NOISE_WAIT;
                end
                ST_NOISE_WAIT: begin
                    if (div_done) begin
                        noise_valid  <= 1'b1;
                        noise_sum    <= nz_sum_q;
                        noise_sumsq  <= nz_sq_q;
                        noise_varnum <= nz_sq_q - SQ_W'(div_quo);
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/linestat_chk.sv
// Checker for linestat_core: protocol and arithmetic properties seen at the
// top-level ports. Attached by the bind at the end of this file.
module linestat_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 13,
    parameter int SUM_W  = 29,
    parameter int IMB_W  = 30,
    parameter int NS_W   = 23,
    parameter int SQ_W   = 39
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     line_end,
    input logic                     busy,
    input logic                     stat_valid,
    input logic [CNT_W-1:0]         stat_count,
    input logic [SUM_W-1:0]         stat_sum,
    input logic [DATA_W-1:0]        stat_mean,
    input logic [DATA_W-1:0]        stat_maxdev,
    input logic signed [IMB_W-1:0]  stat_imb,
    input logic                     noise_valid,
    input logic [SQ_W-1:0]          noise_sumsq,
    input logic [SQ_W-1:0]          noise_varnum
);

    AST_MEAN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_count != '0) |->
        (64'(stat_mean) * 64'(stat_count) <= 64'(stat_sum)) &&
        (64'(stat_sum) < (64'(stat_mean) + 64'd1) * 64'(stat_count))); // R3

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_count == '0) |->
        (stat_sum == '0 && stat_mean == '0 && stat_maxdev == '0 && stat_imb == '0)); // R6

    AST_STAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid); // R7

    AST_BUSY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !busy) |=> busy); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_valid && !$rose(stat_valid)) |-> $stable(stat_mean)); // R7

    AST_NOISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        noise_valid |=> !noise_valid); // R8

    AST_VAR_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        noise_valid |-> noise_varnum <= noise_sumsq); // R8

endmodule

bind linestat_core linestat_chk #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .IMB_W(IMB_W),
    .NS_W(NS_W), .SQ_W(SQ_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .busy(busy),
    .stat_valid(stat_valid), .stat_count(stat_count), .stat_sum(stat_sum),
    .stat_mean(stat_mean), .stat_maxdev(stat_maxdev), .stat_imb(stat_imb),
    .noise_valid(noise_valid), .noise_sumsq(noise_sumsq),
    .noise_varnum(noise_varnum)
);

// File: tb/linestat_core_test.sv
// Directed bench for linestat_core: one task per scenario, each line's
// expected statistics computed from the requirements.
module linestat_core_test;

    localparam int DATA_W = 16;
    localparam int MAXPIX = 7500;
    localparam int NLINES = 4;
    localparam int CNT_W  = $clog2(MAXPIX + 1);
    localparam int SUM_W  = DATA_W + CNT_W;
    localparam int IMB_W  = DATA_W + CNT_W + 1;
    localparam int NL_W   = $clog2(NLINES + 1);
    localparam int NS_W   = DATA_W + NL_W;
    localparam int SQ_W   = 2 * DATA_W + NL_W;
    localparam int NZ_IDX = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_odd = 1'b0;
    logic line_start = 1'b0;
    logic line_end = 1'b0;
    logic [CNT_W-1:0] noise_idx = CNT_W'(NZ_IDX);
    logic busy, stat_valid, noise_valid;
    logic [CNT_W-1:0] stat_count;
    logic [SUM_W-1:0] stat_sum;
    logic [DATA_W-1:0] stat_mean, stat_maxdev;
    logic signed [IMB_W-1:0] stat_imb;
    logic [NS_W-1:0] noise_sum;
    logic [SQ_W-1:0] noise_sumsq, noise_varnum;

    linestat_core #(.DATA_W(DATA_W), .MAX_PIX(MAXPIX), .NOISE_LINES(NLINES)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_odd(in_odd), .line_start(line_start), .line_end(line_end),
        .noise_idx(noise_idx), .busy(busy), .stat_valid(stat_valid),
        .stat_count(stat_count), .stat_sum(stat_sum), .stat_mean(stat_mean),
        .stat_maxdev(stat_maxdev), .stat_imb(stat_imb),
        .noise_valid(noise_valid), .noise_sum(noise_sum),
        .noise_sumsq(noise_sumsq), .noise_varnum(noise_varnum)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // Line description shared by the scenario tasks.
    logic [DATA_W-1:0] lp [64];
    logic lo [64];
    logic lv [64];

    // Noise model across lines.
    int nz_n = 0;
    longint nz_s = 0;
    longint nz_q = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_sig(input int which);
        int t;
        t = 0;
        while (((which == 0) ? stat_valid : noise_valid) !== 1'b1 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) chk("R7", "strobe timeout", 0, 1);
    endtask

    // Drive a line of len slots, then check the report against the model.
    task automatic run_line(input int len, input bit end_on_last);
        longint cnt, sum, mn, mx, imb, hold, mean, up, dn, dev, vidx;
        bit have;
        cnt = 0; sum = 0; mn = 0; mx = 0; imb = 0; hold = 0; have = 0; vidx = 0;
        for (int k = 0; k < len; k++) begin
            if (lv[k]) begin
                if (cnt == 0) begin mn = lp[k]; mx = lp[k]; end
                if (lp[k] < mn) mn = lp[k];
                if (lp[k] > mx) mx = lp[k];
                cnt++; sum += lp[k];
                if (lo[k]) begin hold = lp[k]; have = 1; end
                else if (have) begin imb += hold - longint'(lp[k]); have = 0; end
                if (vidx == NZ_IDX) begin nz_n++; nz_s += lp[k]; nz_q += longint'(lp[k]) * lp[k]; end
                vidx++;
            end
        end
        mean = (cnt != 0) ? sum / cnt : 0;
        up = mx - mean; dn = mean - mn;
        dev = (up > dn) ? up : dn;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = lv[k]; in_data = lp[k]; in_odd = lo[k];
            line_start = (k == 0);
            line_end = end_on_last && (k == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_data = 16'hFFFF; in_odd = 1'b1; line_start = 1'b0;
        line_end = !end_on_last;
        @(negedge clk);
        line_end = 1'b0;
        chk("R7", "busy during report", longint'(busy), 1);
        wait_sig(0);
        chk("R2", "count", longint'(stat_count), cnt);
        chk("R2", "sum", longint'(stat_sum), sum);
        chk("R3", "mean", longint'(stat_mean), mean);
        chk("R4", "maxdev", longint'(stat_maxdev), dev);
        chk("R5", "imbalance", longint'(stat_imb), imb);
        @(negedge clk);
        chk("R7", "strobe width", longint'(stat_valid), 0);
        chk("R7", "mean held", longint'(stat_mean), mean);
        if (nz_n == NLINES) begin
            wait_sig(1);
            chk("R8", "noise sum", longint'(noise_sum), nz_s);
            chk("R8", "noise sumsq", longint'(noise_sumsq), nz_q);
            chk("R8", "noise varnum", longint'(noise_varnum), nz_q - (nz_s * nz_s) / NLINES);
            nz_n = 0; nz_s = 0; nz_q = 0;
        end
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "stat_valid", longint'(stat_valid), 0);
        chk("R1", "noise_valid", longint'(noise_valid), 0);
        chk("R1", "busy", longint'(busy), 0);
        chk("R1", "mean", longint'(stat_mean), 0);
        chk("R1", "varnum", longint'(noise_varnum), 0);
    endtask

    task automatic t_ramp();
        for (int k = 0; k < 10; k++) begin lp[k] = 16'(100 + 7 * k); lo[k] = (k % 2 == 0); lv[k] = 1; end
        run_line(10, 0);
    endtask

    task automatic t_flat_end_on_last();  // R2: pixel in line_end cycle counted
        for (int k = 0; k < 8; k++) begin lp[k] = 16'd500; lo[k] = (k % 2 == 0); lv[k] = 1; end
        run_line(8, 1);
    endtask

    task automatic t_empty();  // R6, R9: no pixels, no sample
        lp[0] = 16'd77; lo[0] = 1; lv[0] = 0;
        run_line(1, 0);
    endtask

    task automatic t_spike_gaps();  // R4 high side, R10 gaps with junk
        for (int k = 0; k < 16; k++) begin
            lv[k] = (k % 4 != 3); lo[k] = (k % 2 == 0);
            lp[k] = lv[k] ? ((k == 9) ? 16'd5000 : 16'd1000) : 16'hFFFF;
        end
        run_line(16, 0);
    endtask

    task automatic t_dip();  // R4 low side; closes first noise batch (R8)
        for (int k = 0; k < 9; k++) begin lp[k] = (k == 5) ? 16'd10 : 16'd3000; lo[k] = (k % 2 == 0); lv[k] = 1; end
        run_line(9, 0);
    endtask

    task automatic t_junk_then_short();  // R2 discard, R9 short line
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 16'd9000; in_odd = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        lp[0] = 16'd40; lo[0] = 1; lv[0] = 1;
        lp[1] = 16'd30; lo[1] = 0; lv[1] = 1;
        run_line(2, 0);
    endtask

    task automatic t_imb_order();  // R5 even first, odd replaced
        logic o [7] = '{0, 1, 1, 0, 0, 1, 0};
        for (int k = 0; k < 7; k++) begin lp[k] = 16'(200 + 37 * k * k); lo[k] = o[k]; lv[k] = 1; end
        run_line(7, 0);
    endtask

    task automatic t_extremes();
        for (int k = 0; k < 16; k++) begin lp[k] = (k % 2 == 0) ? 16'hFFFF : 16'h0000; lo[k] = (k % 2 == 0); lv[k] = 1; end
        run_line(16, 0);
    endtask

    task automatic t_mixed(input int seed);  // closes second noise batch (R8)
        for (int k = 0; k < 20; k++) begin
            lp[k] = 16'((seed * 977 + k * 4099 + k * k * 31) % 60000);
            lo[k] = ((k + seed) % 2 == 0); lv[k] = (k % 7 != 4);
        end
        run_line(20, seed % 2 == 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ramp();
        t_flat_end_on_last();
        t_empty();
        t_spike_gaps();
        t_dip();
        t_junk_then_short();
        t_imb_order();
        t_extremes();
        t_mixed(3);
        t_mixed(8);
        chk("R8", "batch drained", longint'(nz_n), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule